// File: doc/BRIEF.md
# Parallel Flash Command Interface Controller

This block is the command front end of a byte-wide parallel NOR flash, modelled in a synchronous clock domain. A host writes commands by pulsing a write-enable strobe while chip-enable is held low. On the strobe's rising edge the block latches the address and data bus. It then decodes the command into one of three read views: the memory array, a fixed two-byte identifier, or an 8-bit status word. Reads are combinational from the address input through the selected view.

Byte write and block erase are two-cycle sequences. When a sequence is accepted, the block starts an internal program/erase engine. The engine stays busy for a configurable number of cycles and drives a ready output. The array is a small byte-addressed memory that resets to the erased value FFh. The programming-voltage level is a single input flag. It is sampled when the second cycle of a sequence arrives.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: A command is taken only on a rising edge of `we_n` seen while `ce_n` is low. A strobe with `ce_n` high has no effect.
- R2: After reset, and in the cycle after `pwr_dn` is high, the read view is the array. After reset, `rdy` is 1 and every array byte reads FFh.
- R3: Command FFh selects the array view, in which `dout` is the byte at `addr`.
- R4: Command 90h selects the identifier view, in which address 0 reads 89h, address 1 reads A2h and other addresses read 00h. The view persists until another command changes it.
- R5: Command 70h selects the status view. The status byte is laid out as follows:
  - bit 7: ready (1) or busy (0)
  - bit 6: always 0
  - bit 5: erase error
  - bit 4: write error
  - bit 3: low programming voltage
  - bits 2..0: always 0
- R6: Command 40h followed by a data cycle programs the addressed byte to (old AND data). During this, `rdy` is 0 for BUSY_CYC cycles, and reads show status once the setup cycle is taken.
- R7: Command 20h followed by D0h erases a block. The block is the one holding the confirm address, where block = `addr[AW-1:BLK_AW]`. Every byte of that block becomes FFh.
- R8: After 20h, any second byte other than D0h sets status bits 5 and 4 and leaves the array unchanged.
- R9: If `vpp_ok` is 0 when the second cycle of a write or erase arrives, the operation does not start. In that case bit 3 is set together with bit 4 (write) or bit 5 (erase), and the array is unchanged.
- R10: While busy, every command except 70h is ignored, including FFh.
- R11: Error bits 5..3 are sticky across later operations. Only command 50h, taken while idle, clears them.
- R12: Any command byte not listed above returns the read view to the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe, active low, latched on rising edge |
| addr | input | AW | Byte address for commands and reads |
| din | input | 8 | Command or program data |
| vpp_ok | input | 1 | Programming voltage present |
| pwr_dn | input | 1 | Powerdown request, forces array view |
| dout | output | 8 | Read data of the selected view |
| rdy | output | 1 | Ready (1) / busy (0) |

## Verification
Two events can arrive together: a new command decode and a running program/erase operation. The bench provokes this by writing FFh a few cycles after starting a byte write, while `rdy` is still low. It then judges the result at the outputs: the status view must remain selected, showing 00h while busy and 80h once finished. The bench also lands a low-voltage fault and a clear command on either side of a successful write, to show that error state survives a new operation.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam logic [7:0] CMD_ARRAY   = 8'hFF;
  localparam logic [7:0] CMD_IDENT   = 8'h90;
  localparam logic [7:0] CMD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_CLEAR   = 8'h50;
  localparam logic [7:0] CMD_PROG    = 8'h40;
  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] ID_MAKER    = 8'h89;
  localparam logic [7:0] ID_DEVICE   = 8'hA2;

  typedef enum logic [1:0] {V_ARRAY, V_IDENT, V_STATUS} view_t;
  typedef enum logic [1:0] {Q_IDLE, Q_PROG, Q_ERASE} seq_t;
endpackage

// File: rtl/flash_wr_strobe.sv
module flash_wr_strobe #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output logic          cap_v,
  output logic [AW-1:0] cap_addr,
  output logic [7:0]    cap_data
);
  logic we_q;
  logic edge_hit;

  assign edge_hit = !we_q && we_n && !ce_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q     <= 1'b1;
      cap_v    <= 1'b0;
      cap_addr <= '0;
      cap_data <= '0;
    end else begin
      we_q  <= we_n;
      cap_v <= edge_hit;
      if (edge_hit) begin
        cap_addr <= addr;
        cap_data <= din;
      end
    end
  end

  // R1
  strobe_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> !cap_v);
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_dn,
  input  logic          vpp_ok,
  input  logic          busy,
  input  logic          cap_v,
  input  logic [AW-1:0] cap_addr,
  input  logic [7:0]    cap_data,
  output view_t         view,
  output logic          prog_go,
  output logic          erase_go,
  output logic [AW-1:0] go_addr,
  output logic [7:0]    go_data,
  output logic          err_erase,
  output logic          err_prog,
  output logic          err_vpp
);
  view_t view_d;
  seq_t  seq_q, seq_d;
  logic  ee_d, ep_d, ev_d;

  assign go_addr = cap_addr;
  assign go_data = cap_data;

  always_comb begin
    view_d   = view;
    seq_d    = seq_q;
    ee_d     = err_erase;
    ep_d     = err_prog;
    ev_d     = err_vpp;
    prog_go  = 1'b0;
    erase_go = 1'b0;
    if (pwr_dn) begin
      view_d = V_ARRAY;
      seq_d  = Q_IDLE;
    end else if (cap_v) begin
      case (seq_q)
        Q_PROG: begin
          seq_d = Q_IDLE;
          if (vpp_ok) prog_go = 1'b1;
          else begin
            ep_d = 1'b1;
            ev_d = 1'b1;
          end
        end
        Q_ERASE: begin
          seq_d = Q_IDLE;
          if (cap_data != CMD_CONFIRM) begin
            ee_d = 1'b1;
            ep_d = 1'b1;
          end else if (vpp_ok) erase_go = 1'b1;
          else begin
            ee_d = 1'b1;
            ev_d = 1'b1;
          end
        end
        default: begin
          if (busy) begin
            if (cap_data == CMD_STATUS) view_d = V_STATUS;
          end else begin
            case (cap_data)
              CMD_ARRAY:  view_d = V_ARRAY;
              CMD_IDENT:  view_d = V_IDENT;
              CMD_STATUS: view_d = V_STATUS;
              CMD_CLEAR: begin
                ee_d = 1'b0;
                ep_d = 1'b0;
                ev_d = 1'b0;
              end
              CMD_PROG: begin
                view_d = V_STATUS;
                seq_d  = Q_PROG;
              end
              CMD_ERASE: begin
                view_d = V_STATUS;
                seq_d  = Q_ERASE;
              end
              default: view_d = V_ARRAY;
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      view      <= V_ARRAY;
      seq_q     <= Q_IDLE;
      err_erase <= 1'b0;
      err_prog  <= 1'b0;
      err_vpp   <= 1'b0;
    end else begin
      view      <= view_d;
      seq_q     <= seq_d;
      err_erase <= ee_d;
      err_prog  <= ep_d;
      err_vpp   <= ev_d;
    end
  end

  // R2
  pwrdn_array_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> view == V_ARRAY);
  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cap_v && !pwr_dn && seq_q == Q_IDLE && cap_data != CMD_STATUS)
      |=> view == $past(view));
  // R11
  clear_errs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_v && !busy && !pwr_dn && seq_q == Q_IDLE && cap_data == CMD_CLEAR)
      |=> !err_erase && !err_prog && !err_vpp);
endmodule

// File: rtl/flash_wsm.sv
module flash_wsm #(
  parameter int AW       = 6,
  parameter int BLK_AW   = 4,
  parameter int BUSY_CYC = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_go,
  input  logic          erase_go,
  input  logic [AW-1:0] go_addr,
  input  logic [7:0]    go_data,
  input  logic [AW-1:0] rd_addr,
  output logic          busy,
  output logic [7:0]    rd_data
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(BUSY_CYC + 1);

  logic [7:0]    mem   [DEPTH];
  logic [7:0]    mem_d [DEPTH];
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_d;

  assign rd_data = mem[rd_addr];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      mem_d[i] = mem[i];
      if (erase_go && ((i >> BLK_AW) == int'(go_addr[AW-1:BLK_AW])))
        mem_d[i] = 8'hFF;
    end
    if (prog_go) mem_d[go_addr] = mem[go_addr] & go_data;
  end

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy;
    if (prog_go || erase_go) begin
      cnt_d  = CW'(BUSY_CYC);
      busy_d = 1'b1;
    end else if (busy) begin
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      busy  <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else begin
      cnt_q <= cnt_d;
      busy  <= busy_d;
      for (int i = 0; i < DEPTH; i++) mem[i] <= mem_d[i];
    end
  end

  // R10
  no_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_go || erase_go) |-> !busy);
  // R6
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_go || erase_go) |=> busy);
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int AW       = 6,
  parameter int BLK_AW   = 4,
  parameter int BUSY_CYC = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  input  logic          vpp_ok,
  input  logic          pwr_dn,
  output logic [7:0]    dout,
  output logic          rdy
);
  logic          cap_v, prog_go, erase_go, busy;
  logic          err_erase, err_prog, err_vpp;
  logic [AW-1:0] cap_addr, go_addr;
  logic [7:0]    cap_data, go_data, arr_data, status;
  view_t         view;

  flash_wr_strobe #(.AW(AW)) u_strobe (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr),
    .din(din), .cap_v(cap_v), .cap_addr(cap_addr), .cap_data(cap_data));

  flash_cmd_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .vpp_ok(vpp_ok), .busy(busy),
    .cap_v(cap_v), .cap_addr(cap_addr), .cap_data(cap_data), .view(view),
    .prog_go(prog_go), .erase_go(erase_go), .go_addr(go_addr),
    .go_data(go_data), .err_erase(err_erase), .err_prog(err_prog),
    .err_vpp(err_vpp));

  flash_wsm #(.AW(AW), .BLK_AW(BLK_AW), .BUSY_CYC(BUSY_CYC)) u_wsm (
    .clk(clk), .rst_n(rst_n), .prog_go(prog_go), .erase_go(erase_go),
    .go_addr(go_addr), .go_data(go_data), .rd_addr(addr), .busy(busy),
    .rd_data(arr_data));

  assign status = {!busy, 1'b0, err_erase, err_prog, err_vpp, 3'b000};
  assign rdy    = !busy;

  always_comb begin
    case (view)
      V_IDENT: begin
        if (addr == AW'(0))      dout = ID_MAKER;
        else if (addr == AW'(1)) dout = ID_DEVICE;
        else                     dout = 8'h00;
      end
      V_STATUS: dout = status;
      default:  dout = arr_data;
    endcase
  end

  // R4
  ident_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (view == V_IDENT && addr == AW'(1)) |-> dout == ID_DEVICE);
endmodule

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1;
  logic          we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = '0;
  logic          vpp_ok = 1'b1;
  logic          pwr_dn = 1'b0;
  logic [7:0]    dout;
  logic          rdy;
  int            n_chk = 0;
  int            n_err = 0;
  bit            done = 0;

  always #2 clk = ~clk;

  flash_cmd_ctrl #(.AW(AW), .BLK_AW(4), .BUSY_CYC(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr),
    .din(din), .vpp_ok(vpp_ok), .pwr_dn(pwr_dn), .dout(dout), .rdy(rdy));

  // fields: write addr, write data, read addr, expected, requirement number
  localparam logic [39:0] VEC [14] = '{
    {8'h00, 8'h90, 8'h00, 8'h89, 8'd4},   // R4 maker code
    {8'h00, 8'h90, 8'h01, 8'hA2, 8'd4},   // R4 device code
    {8'h05, 8'h40, 8'h00, 8'h80, 8'd6},   // R6 setup shows status
    {8'h05, 8'h3C, 8'h00, 8'h80, 8'd6},   // R6 write succeeded
    {8'h00, 8'hFF, 8'h05, 8'h3C, 8'd3},   // R3 programmed byte
    {8'h00, 8'h70, 8'h00, 8'h80, 8'd5},   // R5 status view
    {8'h10, 8'h20, 8'h00, 8'h80, 8'd8},   // R8 erase setup
    {8'h10, 8'h12, 8'h00, 8'hB0, 8'd8},   // R8 bad confirm
    {8'h00, 8'h50, 8'h00, 8'h80, 8'd11},  // R11 clear
    {8'h00, 8'h20, 8'h00, 8'h80, 8'd7},   // R7 erase setup
    {8'h03, 8'hD0, 8'h00, 8'h80, 8'd7},   // R7 confirm
    {8'h00, 8'hFF, 8'h05, 8'hFF, 8'd7},   // R7 block erased
    {8'h00, 8'h90, 8'h00, 8'h89, 8'd4},   // R4 ident again
    {8'h00, 8'h37, 8'h00, 8'hFF, 8'd12}   // R12 invalid code
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic ce = 1'b0);
    @(negedge clk);
    addr = a[AW-1:0]; din = d; ce_n = ce; we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1;
    repeat (3) @(negedge clk);
    ce_n = 1'b1;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] q);
    addr = a[AW-1:0];
    #1 q = dout;
  endtask

  task automatic wait_rdy();
    for (int i = 0; i < 50 && !rdy; i++) @(negedge clk);
  endtask

  initial begin
    logic [7:0] q;
    #100000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog got hang expected completion");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] q;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    check("R2 rdy", {7'd0, rdy}, 8'h01);
    rd(8'h00, q); check("R2 array", q, 8'hFF);
    // R1 strobe with chip-enable high ignored
    wr(8'h00, 8'h90, 1'b1);
    rd(8'h00, q); check("R1", q, 8'hFF);

    for (int i = 0; i < 14; i++) begin
      wr(VEC[i][39:32], VEC[i][31:24]);
      wait_rdy();
      rd(VEC[i][23:16], q);
      check($sformatf("R%0d row %0d", VEC[i][7:0], i), q, VEC[i][15:8]);
    end

    // R4 other address in ident view
    wr(8'h00, 8'h90); rd(8'h02, q); check("R4 other addr", q, 8'h00);

    // R10 FFh during busy ignored
    wr(8'h00, 8'hFF);
    wr(8'h20, 8'h40); wr(8'h20, 8'h0F);
    check("R6 busy rdy", {7'd0, rdy}, 8'h00);
    rd(8'h00, q); check("R6 busy status", q, 8'h00);
    wr(8'h00, 8'hFF);
    rd(8'h00, q); check("R10 still status", q, 8'h00);
    wait_rdy();
    rd(8'h00, q); check("R10 status after", q, 8'h80);
    wr(8'h00, 8'hFF); rd(8'h20, q); check("R6 program", q, 8'h0F);

    // R9 low voltage write
    vpp_ok = 1'b0;
    wr(8'h21, 8'h40); wr(8'h21, 8'h00);
    vpp_ok = 1'b1;
    rd(8'h00, q); check("R9 write vpp", q, 8'h98);
    // R11 sticky through successful write
    wr(8'h22, 8'h40); wr(8'h22, 8'h55); wait_rdy();
    rd(8'h00, q); check("R11 sticky", q, 8'h98);
    wr(8'h00, 8'hFF);
    rd(8'h21, q); check("R9 no change", q, 8'hFF);
    rd(8'h22, q); check("R11 write ran", q, 8'h55);
    wr(8'h00, 8'h50); wr(8'h00, 8'h70);
    rd(8'h00, q); check("R11 cleared", q, 8'h80);

    // R9 low voltage erase
    vpp_ok = 1'b0;
    wr(8'h20, 8'h20); wr(8'h20, 8'hD0);
    vpp_ok = 1'b1;
    rd(8'h00, q); check("R9 erase vpp", q, 8'hA8);
    wr(8'h00, 8'h50); wr(8'h00, 8'hFF);
    rd(8'h22, q); check("R9 erase blocked", q, 8'h55);

    // R2 powerdown returns to array view
    wr(8'h00, 8'h90);
    @(negedge clk); pwr_dn = 1'b1;
    @(negedge clk); pwr_dn = 1'b0;
    rd(8'h22, q); check("R2 powerdown", q, 8'h55);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule